// File: doc/BRIEF.md
# SD/MMC Host Interrupt Status and Completion

This block holds the raw event and error flags of an SD/MMC host controller. The command path, data path and DMA engine report events as single-cycle pulses. Each pulse sets a sticky flag that software clears by writing ones to a register port. A mask register and a global enable decide which pending flags raise the single interrupt line to the processor.

A transfer-complete output tells the request logic when the current request has finished. Which flag it waits on depends on the kind of transfer:

- A command without data finishes on command complete.
- A single-block transfer finishes on data-over.
- A multi-block transfer finishes on auto-stop done.
- When the DMA engine moves the data, a DMA transmit or receive completion flag must also be pending.

A separate error output is high whenever any error-class flag is pending.

Top module: `sdmmc_irq_ctrl`

## Requirements
- R1: After reset, every register reads zero, and `irq_o`, `err_o` and `done_o` are low.
- R2: A pulse on bit b of `evt_i` sets raw status bit b on the next clock edge. The bit stays set, masked or not, until it is cleared. Raw status reads at address 0.
- R3: A write to address 0 clears every raw bit whose write-data bit is 1. All other raw bits are left unchanged.
- R4: If an event pulse and a clearing write hit the same bit in the same cycle, the bit ends up set. This holds for raw status and for DMA status.
- R5: The mask register at address 1 is 16 bits wide and can be read and written. `irq_o` is high only when some raw bit is set and its mask bit is also set.
- R6: Bit 4 of the control register at address 3 is the global interrupt enable. While it is 0, `irq_o` stays low.
- R7: `err_o` is high exactly when the raw status ANDed with 0xBFC2 is nonzero. Bits 2, 3 and 14 never assert it.
- R8: With `xfer_data_i` low, `done_o` equals raw bit 2 (command complete).
- R9: With `xfer_data_i` high and DMA not in use, `done_o` follows the transfer type:
  - single-block: `done_o` equals raw bit 3 (data over);
  - multi-block (`xfer_multi_i` high): `done_o` equals raw bit 14 (auto-stop done).
- R10: DMA status works as follows:
  - Bit 0 (transmit done) and bit 1 (receive done) are set by `dma_evt_i`, read at address 2, and are cleared by writing ones to address 2.
  - With `xfer_data_i` and `xfer_dma_i` both high, `done_o` also requires at least one DMA status bit to be set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| evt_i | input | 16 | Event pulses, one per raw status bit |
| dma_evt_i | input | 2 | DMA transmit (bit 0) and receive (bit 1) completion pulses |
| xfer_data_i | input | 1 | Current request has a data phase |
| xfer_multi_i | input | 1 | Data phase spans more than one block |
| xfer_dma_i | input | 1 | Data is moved by the DMA engine |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 raw, 1 mask, 2 DMA status, 3 control |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data for `reg_addr_i` |
| irq_o | output | 1 | Interrupt line to the processor |
| err_o | output | 1 | Any error-class flag pending |
| done_o | output | 1 | Current request complete |

## Verification
The bench builds the block with its defaults: 16 status bits and error mask 0xBFC2. At that size, each status bit can be pulsed alone and checked against every one-hot mask, with the global enable both on and off. This covers all 256 bit/mask pairings and the error classification of each bit.

The completion logic depends on only three raw bits, two DMA bits and three transfer-type inputs. That gives 256 combinations, and the bench walks through all of them. The same-cycle pulse-and-clear race is driven on both status registers.

// File: rtl/sdmmc_irq_pkg.sv
package sdmmc_irq_pkg;
  localparam int unsigned BIT_CMD_DONE  = 2;
  localparam int unsigned BIT_DATA_OVER = 3;
  localparam int unsigned BIT_AUTOSTOP  = 14;
  localparam int unsigned GIE_BIT       = 4;
  localparam int unsigned DMA_W         = 2;

  typedef enum logic [1:0] {
    A_RAW  = 2'd0,
    A_MASK = 2'd1,
    A_DMA  = 2'd2,
    A_CTRL = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/sdmmc_sticky_flags.sv
module sdmmc_sticky_flags #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic q;
    // set beats clear in the same cycle
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q <= 1'b0;
      else if (set_i[i]) q <= 1'b1;
      else if (clr_i[i]) q <= 1'b0;
    end
    assign q_o[i] = q;
  end
endmodule

// File: rtl/sdmmc_flag_reduce.sv
module sdmmc_flag_reduce #(
  parameter int unsigned   W        = 16,
  parameter logic [W-1:0]  ERR_BITS = '0
) (
  input  logic [W-1:0] raw_i,
  input  logic [W-1:0] mask_i,
  input  logic         gie_i,
  output logic         irq_o,
  output logic         err_o
);
  assign irq_o = gie_i & (|(raw_i & mask_i));
  assign err_o = |(raw_i & ERR_BITS);
endmodule

// File: rtl/sdmmc_done_eval.sv
module sdmmc_done_eval #(
  parameter int unsigned DMA_W = 2
) (
  input  logic             cmd_done_i,
  input  logic             data_over_i,
  input  logic             autostop_i,
  input  logic [DMA_W-1:0] dma_stat_i,
  input  logic             xfer_data_i,
  input  logic             xfer_multi_i,
  input  logic             xfer_dma_i,
  output logic             done_o
);
  logic data_flag;
  logic dma_ok;

  always_comb begin
    data_flag = xfer_multi_i ? autostop_i : data_over_i;
    dma_ok    = !xfer_dma_i || (|dma_stat_i);
    done_o    = xfer_data_i ? (data_flag && dma_ok) : cmd_done_i;
  end
endmodule

// File: rtl/sdmmc_irq_ctrl.sv
module sdmmc_irq_ctrl
  import sdmmc_irq_pkg::*;
#(
  parameter int unsigned       STAT_W   = 16,
  parameter logic [STAT_W-1:0] ERR_BITS = 16'hBFC2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [STAT_W-1:0] evt_i,
  input  logic [DMA_W-1:0]  dma_evt_i,
  input  logic              xfer_data_i,
  input  logic              xfer_multi_i,
  input  logic              xfer_dma_i,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [STAT_W-1:0] reg_wdata_i,
  output logic [STAT_W-1:0] reg_rdata_o,
  output logic              irq_o,
  output logic              err_o,
  output logic              done_o
);
  logic [STAT_W-1:0] raw_q;
  logic [STAT_W-1:0] raw_clr;
  logic [DMA_W-1:0]  dma_q;
  logic [DMA_W-1:0]  dma_clr;
  logic [STAT_W-1:0] mask_q;
  logic              gie_q;
  reg_addr_e         addr;

  assign addr    = reg_addr_e'(reg_addr_i);
  assign raw_clr = (reg_we_i && addr == A_RAW) ? reg_wdata_i : '0;
  assign dma_clr = (reg_we_i && addr == A_DMA) ? reg_wdata_i[DMA_W-1:0] : '0;

  sdmmc_sticky_flags #(.W(STAT_W)) u_raw (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (evt_i),
    .clr_i (raw_clr),
    .q_o   (raw_q)
  );

  sdmmc_sticky_flags #(.W(DMA_W)) u_dma (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (dma_evt_i),
    .clr_i (dma_clr),
    .q_o   (dma_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      gie_q  <= 1'b0;
    end else if (reg_we_i) begin
      if (addr == A_MASK) mask_q <= reg_wdata_i;
      if (addr == A_CTRL) gie_q  <= reg_wdata_i[GIE_BIT];
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (addr)
      A_RAW:  reg_rdata_o = raw_q;
      A_MASK: reg_rdata_o = mask_q;
      A_DMA:  reg_rdata_o[DMA_W-1:0] = dma_q;
      A_CTRL: reg_rdata_o[GIE_BIT] = gie_q;
    endcase
  end

  sdmmc_flag_reduce #(.W(STAT_W), .ERR_BITS(ERR_BITS)) u_reduce (
    .raw_i (raw_q),
    .mask_i(mask_q),
    .gie_i (gie_q),
    .irq_o (irq_o),
    .err_o (err_o)
  );

  sdmmc_done_eval #(.DMA_W(DMA_W)) u_done (
    .cmd_done_i  (raw_q[BIT_CMD_DONE]),
    .data_over_i (raw_q[BIT_DATA_OVER]),
    .autostop_i  (raw_q[BIT_AUTOSTOP]),
    .dma_stat_i  (dma_q),
    .xfer_data_i (xfer_data_i),
    .xfer_multi_i(xfer_multi_i),
    .xfer_dma_i  (xfer_dma_i),
    .done_o      (done_o)
  );
endmodule

// File: rtl/sdmmc_irq_chk.sv
module sdmmc_irq_chk #(
  parameter int unsigned       STAT_W   = 16,
  parameter logic [STAT_W-1:0] ERR_BITS = 16'hBFC2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [STAT_W-1:0] evt_i,
  input logic [1:0]        dma_evt_i,
  input logic              reg_we_i,
  input logic [1:0]        reg_addr_i,
  input logic [STAT_W-1:0] reg_wdata_i,
  input logic [STAT_W-1:0] raw_q,
  input logic [1:0]        dma_q,
  input logic [STAT_W-1:0] mask_q,
  input logic              gie_q,
  input logic              xfer_data_i,
  input logic              xfer_dma_i,
  input logic              irq_o,
  input logic              err_o,
  input logic              done_o
);
  // R2: set flags persist unless a raw-clear write occurs
  a_r2_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_we_i && reg_addr_i == 2'd0) |=> ((raw_q & $past(raw_q)) == $past(raw_q)));

  // R4: a pulse always lands, even against a clear
  a_r4_event_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((raw_q & $past(evt_i)) == $past(evt_i)));

  a_r4_dma_event_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((dma_q & $past(dma_evt_i)) == $past(dma_evt_i)));

  // R3: written ones without a competing pulse are gone
  a_r3_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == 2'd0) |=> ((raw_q & $past(reg_wdata_i & ~evt_i)) == '0));

  // R5
  a_r5_irq_needs_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (|(raw_q & mask_q)));

  // R6
  a_r6_gie_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gie_q |-> !irq_o);

  // R7
  a_r7_err_class: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (|(raw_q & ERR_BITS)));

  // R10
  a_r10_dma_qual: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && xfer_data_i && xfer_dma_i) |-> (|dma_q));
endmodule

bind sdmmc_irq_ctrl sdmmc_irq_chk #(.STAT_W(STAT_W), .ERR_BITS(ERR_BITS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .evt_i      (evt_i),
  .dma_evt_i  (dma_evt_i),
  .reg_we_i   (reg_we_i),
  .reg_addr_i (reg_addr_i),
  .reg_wdata_i(reg_wdata_i),
  .raw_q      (raw_q),
  .dma_q      (dma_q),
  .mask_q     (mask_q),
  .gie_q      (gie_q),
  .xfer_data_i(xfer_data_i),
  .xfer_dma_i (xfer_dma_i),
  .irq_o      (irq_o),
  .err_o      (err_o),
  .done_o     (done_o)
);

// File: tb/sim_sdmmc_irq_ctrl.sv
module sim_sdmmc_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] ERR = 16'hBFC2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] evt = '0;
  logic [1:0]  dma_evt = '0;
  logic        x_data = 1'b0, x_multi = 1'b0, x_dma = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq, err, done;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdmmc_irq_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .dma_evt_i(dma_evt),
    .xfer_data_i(x_data), .xfer_multi_i(x_multi), .xfer_dma_i(x_dma),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq), .err_o(err), .done_o(done)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic pulse(input logic [15:0] e, input logic [1:0] de);
    @(negedge clk);
    evt = e; dma_evt = de;
    @(negedge clk);
    evt = '0; dma_evt = '0;
  endtask

  task automatic clear_all();
    wr(2'd0, 16'hFFFF);
    wr(2'd2, 16'h0003);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] v;
    #(CLK_PERIOD * 3);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], v);
      chk("R1 reg zero", v, 16'h0);
    end
    chk("R1 irq", {15'b0, irq}, 16'h0);
    chk("R1 err", {15'b0, err}, 16'h0);
    chk("R1 done", {15'b0, done}, 16'h0);

    // R5 mask readback
    wr(2'd1, 16'hA5C3);
    rd(2'd1, v);
    chk("R5 mask rw", v, 16'hA5C3);

    // R6 gie readback at bit 4
    wr(2'd3, 16'hFFFF);
    rd(2'd3, v);
    chk("R6 ctrl rw", v, 16'h0010);

    // per-bit sweep: R2, R7, R5, R6, R3
    for (int b = 0; b < 16; b++) begin
      clear_all();
      pulse(16'(1) << b, 2'b00);
      repeat (2) @(negedge clk);
      rd(2'd0, v);
      chk("R2 sticky set", v, 16'(1) << b);
      chk("R7 err class", {15'b0, err}, {15'b0, ERR[b]});
      wr(2'd3, 16'h0010);
      for (int m = 0; m < 16; m++) begin
        wr(2'd1, 16'(1) << m);
        chk("R5 masked irq", {15'b0, irq}, {15'b0, (m == b)});
      end
      wr(2'd1, 16'hFFFF);
      wr(2'd3, 16'h0000);
      chk("R6 gie off", {15'b0, irq}, 16'h0);
      rd(2'd0, v);
      chk("R2 masked kept", v, 16'(1) << b);
      wr(2'd0, ~(16'(1) << b));
      rd(2'd0, v);
      chk("R3 other bits kept", v, 16'(1) << b);
      wr(2'd0, 16'(1) << b);
      rd(2'd0, v);
      chk("R3 w1c", v, 16'h0);
    end

    // R4 same-cycle race on raw
    clear_all();
    pulse(16'h0040, 2'b01);
    @(negedge clk);
    evt = 16'h0020; we = 1'b1; addr = 2'd0; wdata = 16'h0060;
    @(negedge clk);
    evt = '0; we = 1'b0;
    rd(2'd0, v);
    chk("R4 raw event wins", v, 16'h0020);

    // R4/R10 same-cycle race on DMA status
    @(negedge clk);
    dma_evt = 2'b10; we = 1'b1; addr = 2'd2; wdata = 16'h0003;
    @(negedge clk);
    dma_evt = '0; we = 1'b0;
    rd(2'd2, v);
    chk("R4 dma event wins", v, 16'h0002);
    wr(2'd2, 16'h0002);
    rd(2'd2, v);
    chk("R10 dma w1c", v, 16'h0000);

    // completion sweep: R8, R9, R10
    for (int t = 0; t < 8; t++) begin
      for (int s = 0; s < 8; s++) begin
        for (int d = 0; d < 4; d++) begin
          logic [15:0] e;
          logic exp_done, dflag;
          clear_all();
          @(negedge clk);
          x_data = t[0]; x_multi = t[1]; x_dma = t[2];
          e = '0;
          e[2] = s[0]; e[3] = s[1]; e[14] = s[2];
          pulse(e, d[1:0]);
          dflag = t[1] ? s[2] : s[1];
          if (!t[0]) exp_done = s[0];
          else       exp_done = dflag && (!t[2] || d != 0);
          if (!t[0])      chk("R8 cmd done", {15'b0, done}, {15'b0, exp_done});
          else if (!t[2]) chk("R9 data done", {15'b0, done}, {15'b0, exp_done});
          else            chk("R10 dma done", {15'b0, done}, {15'b0, exp_done});
        end
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule